// File: doc/BRIEF.md
# Event Timer Global Register Block

This block owns the shared registers of a multi-channel event timer and decodes its 1 KiB memory-mapped window. It provides a read-only capability word, a two-bit general configuration register (overall enable and legacy interrupt routing), a write-one-to-clear interrupt status register fed by the channels, and a 64-bit main up-counter that advances on a tick-enable pulse while enabled and holds its value while halted.

Accesses are 32 or 64 bits wide. Address bit 2 steers a 32-bit access to the upper half of a 64-bit register. Addresses in the per-channel area are turned into a one-hot channel select, a register code and an upper-half flag. The channel supplies its full 64-bit register word back for reads. The comparator channels and the interrupt pins live outside the block. They see a one-cycle pulse on every change of the overall enable, and a one-cycle clear pulse for every status bit that software clears.

Top module: `evt_glob_regs`

## Requirements
- R1: After a synchronous reset the counter, configuration, status, read data, clear pulses and enable-change pulse are all 0.
- R2: The capability word at offset 0x000 reads as follows: revision 1 in bits 7:0, channel count minus one in bits 12:8, a 1 in bit 13 and in bit 15, zero in bits 31:16, and the tick period in femtoseconds (default 10,000,000) in bits 63:32. Writes to it change nothing.
- R3: At offset 0x010 only bits 1:0 can be written: bit 0 is the overall enable (glob_en) and bit 1 is legacy routing (legacy_route). All other bits read as 0.
- R4: When address bit 2 is 1, a read returns bits 63:32 in the low 32 data bits, and a write loads data bits 31:0 into bits 63:32. This holds for both access widths. When bit 2 is 0, a 32-bit access uses bits 31:0 and a 64-bit access uses the whole register. On a 32-bit read the upper 32 data bits are 0.
- R5: A write to offset 0x020 clears every set status bit whose written data bit is 1. A status-set input arriving in the same cycle keeps its bit set. One cycle after the write, sts_clr pulses exactly the bits that were cleared.
- R6: The counter at offset 0x0F0 increases by one on each clock with tick_en high while enabled. While halted it holds its value. A read returns the count as it stands at the sampling edge.
- R7: The counter can be written in either state. A write takes precedence over the increment in the same cycle.
- R8: en_edge is high for exactly one cycle, the same cycle glob_en takes a new value. A configuration write that leaves bit 0 unchanged produces no pulse.
- R9: Channel N occupies 0x100+0x20*N. Sub-offsets +0x00, +0x08 and +0x10 give tmr_reg codes 0, 1 and 2. During an access, tmr_sel is one-hot on N. Channel N's word is returned through the lane rules of R4.
- R10: An unmapped offset drives no channel select, reads as 0 and ignores writes. Unmapped offsets include a channel index at or above NT and sub-offset +0x18.
- R11: bus_rdata is registered: it updates on the clock edge that samples bus_rd and holds between reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Counter tick enable pulse |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | AW | Byte address within the window |
| bus_size64 | input | 1 | 1 = 64-bit access, 0 = 32-bit |
| bus_wdata | input | 64 | Write data |
| bus_rdata | output | 64 | Registered read data |
| tmr_sel | output | NT | One-hot channel select during an access |
| tmr_reg | output | 2 | Channel register code (0 config, 1 comparator, 2 route) |
| tmr_upper | output | 1 | Access targets the upper half |
| tmr_rdata | input | 64 | Selected channel's register word |
| sts_set | input | NT | Per-channel status set pulses |
| sts_clr | output | NT | Per-channel status cleared pulses |
| glob_en | output | 1 | Overall enable |
| legacy_route | output | 1 | Legacy routing mode |
| en_edge | output | 1 | One-cycle pulse on an enable change |

## Verification
Every state register is visible through a read one cycle later. A wrong decode therefore shows up on the very next read, either as a wrong select or as nonzero data at a hole, and the full address sweep reaches it. A counter that drifts or steps while halted shows up as an exact miscount on the read that follows a known number of ticks. A wrong status merge shows up at once on sts_clr and on the next status read. A missing or doubled enable-change pulse is visible in the cycle right after the configuration write.

// File: rtl/evt_pkg.sv
package evt_pkg;
  typedef enum logic [2:0] {K_NONE, K_CAP, K_CFG, K_STS, K_CNT, K_TMR} reg_kind_e;

  // place write data into the addressed lane, keep the other half
  function automatic logic [63:0] lane_merge(input logic [63:0] old, input logic [63:0] wd,
                                             input logic upper, input logic wide);
    if (upper)     return {wd[31:0], old[31:0]};
    else if (wide) return wd;
    else           return {old[63:32], wd[31:0]};
  endfunction

  function automatic logic [63:0] lane_read(input logic [63:0] v, input logic upper,
                                            input logic wide);
    if (upper)     return {32'b0, v[63:32]};
    else if (wide) return v;
    else           return {32'b0, v[31:0]};
  endfunction
endpackage

// File: rtl/evt_addr_dec.sv
module evt_addr_dec
  import evt_pkg::*;
#(
  parameter int NT = 3,
  parameter int AW = 10
) (
  input  logic [AW-1:0] addr,
  output reg_kind_e     kind,
  output logic [NT-1:0] sel,
  output logic [1:0]    sub,
  output logic          upper
);
  localparam int IW = AW - 5;

  logic [AW-1:0] a;
  logic [IW-1:0] idx;

  always_comb begin
    a     = {addr[AW-1:3], 3'b000};
    upper = addr[2];
    idx   = a[AW-1:5] - IW'(8);
    sub   = a[4:3];
    kind  = K_NONE;
    if (a[AW-1:8] == '0) begin
      case (a[7:0])
        8'h00:   kind = K_CAP;
        8'h10:   kind = K_CFG;
        8'h20:   kind = K_STS;
        8'hF0:   kind = K_CNT;
        default: kind = K_NONE;
      endcase
    end else if ((int'(idx) < NT) && (sub != 2'd3)) begin
      kind = K_TMR;
    end
    for (int i = 0; i < NT; i++)
      sel[i] = (kind == K_TMR) && (idx == IW'(i));
  end

  always_comb begin
    assert_sel_onehot_R9: assert ($onehot0(sel));
  end
endmodule

// File: rtl/evt_main_ctr.sv
module evt_main_ctr
  import evt_pkg::*;
#(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic         tick,
  input  logic         wr,
  input  logic [63:0]  wdata,
  input  logic         upper,
  input  logic         wide,
  output logic [W-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (rst)            cnt <= '0;
    else if (wr)        cnt <= W'(lane_merge(64'(cnt), wdata, upper, wide));
    else if (en && tick) cnt <= cnt + W'(1);
  end

  assert_halt_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (!en && !wr) |=> $stable(cnt));
  assert_step_R6: assert property (@(posedge clk) disable iff (rst)
    (en && tick && !wr) |=> (cnt == $past(cnt) + W'(1)));
endmodule

// File: rtl/evt_int_status.sv
module evt_int_status #(
  parameter int NT = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NT-1:0] set,
  input  logic          wr,
  input  logic [NT-1:0] wmask,
  output logic [NT-1:0] q,
  output logic [NT-1:0] clr
);
  logic [NT-1:0] kill;

  assign kill = wr ? (wmask & q & ~set) : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      q   <= '0;
      clr <= '0;
    end else begin
      q   <= (q & ~kill) | set;
      clr <= kill;
    end
  end

  assert_w1c_R5: assert property (@(posedge clk) disable iff (rst)
    (|kill) |=> ((q & $past(kill)) == '0));
  assert_set_wins_R5: assert property (@(posedge clk) disable iff (rst)
    (|set) |=> ((q & $past(set)) == $past(set)));
endmodule

// File: rtl/evt_glob_regs.sv
module evt_glob_regs
  import evt_pkg::*;
#(
  parameter int NT      = 3,
  parameter int AW      = 10,
  parameter int TICK_FS = 10000000,
  parameter int REV     = 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick_en,
  input  logic          bus_rd,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_size64,
  input  logic [63:0]   bus_wdata,
  output logic [63:0]   bus_rdata,
  output logic [NT-1:0] tmr_sel,
  output logic [1:0]    tmr_reg,
  output logic          tmr_upper,
  input  logic [63:0]   tmr_rdata,
  input  logic [NT-1:0] sts_set,
  output logic [NT-1:0] sts_clr,
  output logic          glob_en,
  output logic          legacy_route,
  output logic          en_edge
);
  localparam logic [63:0] CAP_WORD = {32'(TICK_FS), 16'h0000, 1'b1, 1'b0, 1'b1,
                                      5'(NT - 1), 8'(REV)};

  reg_kind_e     kind;
  logic [NT-1:0] sel;
  logic [1:0]    sub;
  logic          upper;
  logic [1:0]    cfg_q;
  logic [1:0]    cfg_nx;
  logic [63:0]   cnt;
  logic [NT-1:0] sts_q;
  logic [63:0]   wmask64;

  evt_addr_dec #(.NT(NT), .AW(AW)) u_dec (
    .addr(bus_addr), .kind(kind), .sel(sel), .sub(sub), .upper(upper)
  );

  assign tmr_sel   = (bus_rd || bus_wr) ? sel : '0;
  assign tmr_reg   = sub;
  assign tmr_upper = upper;

  evt_main_ctr #(.W(64)) u_ctr (
    .clk(clk), .rst(rst), .en(cfg_q[0]), .tick(tick_en),
    .wr(bus_wr && (kind == K_CNT)), .wdata(bus_wdata), .upper(upper),
    .wide(bus_size64), .cnt(cnt)
  );

  assign wmask64 = lane_merge(64'b0, bus_wdata, upper, bus_size64);

  evt_int_status #(.NT(NT)) u_sts (
    .clk(clk), .rst(rst), .set(sts_set), .wr(bus_wr && (kind == K_STS)),
    .wmask(wmask64[NT-1:0]), .q(sts_q), .clr(sts_clr)
  );

  assign cfg_nx = lane_merge({62'b0, cfg_q}, bus_wdata, upper, bus_size64)[1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q   <= 2'b00;
      en_edge <= 1'b0;
    end else if (bus_wr && (kind == K_CFG)) begin
      cfg_q   <= cfg_nx;
      en_edge <= cfg_nx[0] ^ cfg_q[0];
    end else begin
      en_edge <= 1'b0;
    end
  end

  assign glob_en      = cfg_q[0];
  assign legacy_route = cfg_q[1];

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else if (bus_rd) begin
      case (kind)
        K_CAP:   bus_rdata <= lane_read(CAP_WORD, upper, bus_size64);
        K_CFG:   bus_rdata <= lane_read({62'b0, cfg_q}, upper, bus_size64);
        K_STS:   bus_rdata <= lane_read(64'(sts_q), upper, bus_size64);
        K_CNT:   bus_rdata <= lane_read(cnt, upper, bus_size64);
        K_TMR:   bus_rdata <= lane_read(tmr_rdata, upper, bus_size64);
        default: bus_rdata <= '0;
      endcase
    end
  end

  assert_edge_R8: assert property (@(posedge clk) disable iff (rst)
    en_edge |-> (glob_en != $past(glob_en)));
  assert_no_edge_R8: assert property (@(posedge clk) disable iff (rst)
    (!en_edge) |-> (glob_en == $past(glob_en)));
  assert_hole_zero_R10: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && (kind == K_NONE)) |=> (bus_rdata == '0));
  assert_rd_hold_R11: assert property (@(posedge clk) disable iff (rst)
    (!bus_rd) |=> $stable(bus_rdata));
endmodule

// File: tb/evt_glob_regs_tb.sv
module evt_glob_regs_tb;
  localparam int NT = 4;
  localparam int AW = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick_en = 1'b0, bus_rd = 1'b0, bus_wr = 1'b0, bus_size64 = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [63:0] bus_wdata = '0, bus_rdata, tmr_rdata;
  logic [NT-1:0] tmr_sel, sts_set = '0, sts_clr;
  logic [1:0] tmr_reg;
  logic tmr_upper, glob_en, legacy_route, en_edge;

  int checks = 0, fails = 0, cyc = 0;

  always #4 clk = ~clk;

  evt_glob_regs #(.NT(NT), .AW(AW)) u_dut (
    .clk(clk), .rst(rst), .tick_en(tick_en), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_size64(bus_size64), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .tmr_sel(tmr_sel), .tmr_reg(tmr_reg), .tmr_upper(tmr_upper),
    .tmr_rdata(tmr_rdata), .sts_set(sts_set), .sts_clr(sts_clr), .glob_en(glob_en),
    .legacy_route(legacy_route), .en_edge(en_edge)
  );

  function automatic logic [63:0] chan_word(input int idx, input int rg);
    return {16'hC0DE, 8'(idx), 8'(rg), 32'h5A5A0000 + 32'(idx * 16 + rg)};
  endfunction

  always_comb begin
    tmr_rdata = '0;
    for (int i = 0; i < NT; i++)
      if (tmr_sel[i]) tmr_rdata = chan_word(i, int'(tmr_reg));
  end

  function automatic logic [63:0] lane(input logic [63:0] v, input logic up, input logic w);
    if (up) return {32'b0, v[63:32]};
    return w ? v : {32'b0, v[31:0]};
  endfunction

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      fails++;
      $display("FAIL watchdog: act=%0d cycles exp<150000", cyc);
      summary();
      $finish;
    end
  end

  task automatic check(input string rq, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: act=%h exp=%h", rq, act, exp);
    end
  endtask

  task automatic bwrite(input logic [AW-1:0] a, input logic [63:0] d, input logic w);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_size64 = w; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bread(input logic [AW-1:0] a, input logic w, output logic [63:0] d);
    @(negedge clk);
    bus_addr = a; bus_size64 = w; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  logic [63:0] cap_exp, rd, exp, prev;

  initial begin
    cap_exp = {32'd10000000, 16'h0, 1'b1, 1'b0, 1'b1, 5'(NT - 1), 8'd1};
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 rdata", bus_rdata, 64'h0);
    check("R1 cfg", {62'b0, legacy_route, glob_en}, 64'h0);
    check("R1 pulses", {59'b0, en_edge, sts_clr}, 64'h0);

    // R9 R10 R2 R4 sweep over the whole window, both widths
    for (int a = 0; a < 1024; a += 4) begin
      for (int w = 0; w < 2; w++) begin
        int base, idx, sb;
        logic ok;
        logic [63:0] v;
        base = a & ~4;
        idx = (base - 256) >> 5;
        sb = (base >> 3) & 3;
        ok = (base >= 256) && (idx < NT) && (sb < 3);
        v = 64'h0;
        if (base == 0) v = cap_exp;
        else if (ok) v = chan_word(idx, sb);
        @(negedge clk);
        bus_addr = AW'(a); bus_size64 = w[0]; bus_rd = 1'b1;
        #1;
        check("R9 sel", 64'(tmr_sel), ok ? 64'(1 << idx) : 64'h0);
        if (ok) check("R9 regcode", 64'(tmr_reg), 64'(sb));
        @(negedge clk);
        bus_rd = 1'b0;
        check("R10/R4 sweep read", bus_rdata, lane(v, a[2], w[0]));
      end
    end

    // R11 hold between reads
    bread(10'h000, 1'b1, rd);
    repeat (3) @(negedge clk);
    check("R11 hold", bus_rdata, cap_exp);

    // R2 writes ignored
    bwrite(10'h000, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1);
    bread(10'h000, 1'b1, rd); check("R2 cap after write", rd, cap_exp);
    bread(10'h004, 1'b0, rd); check("R2 cap upper", rd, 64'd10000000);

    // R3 config
    bwrite(10'h010, 64'hFFFF_FFFF_FFFF_FFFE, 1'b1);
    check("R3 legacy", {62'b0, legacy_route, glob_en}, 64'h2);
    check("R8 no edge", 64'(en_edge), 64'h0);
    bread(10'h010, 1'b1, rd); check("R3 readback", rd, 64'h2);
    bwrite(10'h014, 64'hFFFF_FFFF, 1'b0);
    bread(10'h010, 1'b1, rd); check("R3 upper write no effect", rd, 64'h2);

    // R10 hole write ignored
    bwrite(10'h030, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1);
    bwrite(10'h3F8, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1);
    bread(10'h010, 1'b1, rd); check("R10 cfg untouched", rd, 64'h2);
    bread(10'h0F0, 1'b1, rd); check("R10 cnt untouched", rd, 64'h0);

    // R6 halted counter holds
    @(negedge clk); tick_en = 1'b1;
    repeat (6) @(negedge clk); tick_en = 1'b0;
    bread(10'h0F0, 1'b1, rd); check("R6 halted hold", rd, 64'h0);

    // R8 enable edge
    bwrite(10'h010, 64'h1, 1'b0);
    check("R8 rise pulse", 64'(en_edge), 64'h1);
    check("R3 enable", {62'b0, legacy_route, glob_en}, 64'h1);
    @(negedge clk); check("R8 pulse one cycle", 64'(en_edge), 64'h0);

    // R6 counting
    @(negedge clk); tick_en = 1'b1;
    repeat (5) @(negedge clk); tick_en = 1'b0;
    bread(10'h0F0, 1'b1, rd); check("R6 count 5", rd, 64'd5);
    for (int k = 0; k < 8; k++) begin
      @(negedge clk); tick_en = k[0];
    end
    @(negedge clk); tick_en = 1'b0;
    bread(10'h0F0, 1'b0, rd); check("R6 sparse ticks", rd, 64'd9);

    // R7 write while enabled wins over tick
    @(negedge clk); tick_en = 1'b1;
    bus_addr = 10'h0F0; bus_wdata = 64'h100; bus_size64 = 1'b0; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0; tick_en = 1'b0;
    bread(10'h0F0, 1'b1, rd); check("R7 write wins", rd, 64'h100);
    @(negedge clk); tick_en = 1'b1;
    repeat (2) @(negedge clk); tick_en = 1'b0;
    bread(10'h0F0, 1'b1, rd); check("R7 resumes", rd, 64'h102);

    // R8 fall edge, then halted writes R7 R4
    bwrite(10'h010, 64'h0, 1'b1);
    check("R8 fall pulse", 64'(en_edge), 64'h1);
    bwrite(10'h010, 64'h0, 1'b1);
    check("R8 same value no pulse", 64'(en_edge), 64'h0);
    bwrite(10'h0F4, 64'hFFFF_0000_0000_1234, 1'b1);
    bread(10'h0F0, 1'b1, rd); check("R4 upper write", rd, 64'h0000_1234_0000_0102);
    bread(10'h0F4, 1'b1, rd); check("R4 upper read", rd, 64'h1234);
    bwrite(10'h0F0, 64'hDEAD_BEEF_0BAD_F00D, 1'b1);
    bread(10'h0F0, 1'b1, rd); check("R7 wide write", rd, 64'hDEAD_BEEF_0BAD_F00D);
    bread(10'h0F0, 1'b0, rd); check("R4 narrow low", rd, 64'h0BAD_F00D);
    @(negedge clk); tick_en = 1'b1;
    repeat (3) @(negedge clk); tick_en = 1'b0;
    bread(10'h0F0, 1'b1, rd); check("R6 halted after write", rd, 64'hDEAD_BEEF_0BAD_F00D);

    // R5 status
    @(negedge clk); sts_set = 4'b1010;
    @(negedge clk); sts_set = 4'b0000;
    bread(10'h020, 1'b1, rd); check("R5 set", rd, 64'hA);
    bwrite(10'h020, 64'h2, 1'b0);
    check("R5 clr pulse", 64'(sts_clr), 64'h2);
    @(negedge clk); check("R5 clr one cycle", 64'(sts_clr), 64'h0);
    bread(10'h020, 1'b1, rd); check("R5 after clear", rd, 64'h8);
    bwrite(10'h024, 64'hF, 1'b0);
    check("R5 upper no clear", 64'(sts_clr), 64'h0);
    bwrite(10'h020, 64'h0, 1'b1);
    bread(10'h020, 1'b1, rd); check("R5 zero write", rd, 64'h8);
    @(negedge clk);
    sts_set = 4'b1000; bus_addr = 10'h020; bus_wdata = 64'h8; bus_size64 = 1'b0; bus_wr = 1'b1;
    @(negedge clk); sts_set = '0; bus_wr = 1'b0;
    check("R5 set wins clr", 64'(sts_clr), 64'h0);
    bread(10'h020, 1'b1, rd); check("R5 set wins state", rd, 64'h8);
    bwrite(10'h020, 64'hF, 1'b1);
    check("R5 clr only set bits", 64'(sts_clr), 64'h8);
    bread(10'h020, 1'b1, rd); check("R5 all clear", rd, 64'h0);

    summary();
    $finish;
  end
endmodule